// File: doc/BRIEF.md
# Audio master clock ratio divider

This block derives an audio master clock from a fast reference clock by halving that clock a selectable number of times. One select bit names the clock family: in one family the family clock is 512 times the sample rate, in the other 384 times. A three-bit ratio code picks a power-of-two divisor, so the output sits at 512, 256, 128, 64 or 32 times the sample rate in the first family and at 384, 192, 96 or 48 times in the second. Sample rates from 8 kHz to 192 kHz are covered by choosing the reference frequency.

The block clock `clk` runs at twice the family clock, with one `clk` cycle per half period of the family clock. Code k makes `mclk` toggle every 2^k cycles, which gives the family clock divided by 2^k. All divided phases come from one free-running five-bit counter. A new code, a new family and a restart all take effect only when that counter wraps. At a wrap every phase begins a fresh period with the output low, so no runt pulse can appear. A gate input and a run input stop the output at once. A synchronous soft reset clears the counter and all state. `mclk_tick` reports every output transition, and `cfg_err` latches the use of an illegal code.

Top module: `mclk_ratio_div`

## Requirements
- R1: While `rst_n` is low at a clock edge, `mclk`, `mclk_tick` and `cfg_err` are 0 after that edge.
- R2: With `base_sel`=0, `run`=1 and `gate`=0, codes 0 to 4 make `mclk` a square wave with period 2^(code+1) clk cycles, giving 512, 256, 128, 64 and 32 times the sample rate.
- R3: With `base_sel`=1, codes 0 to 3 make `mclk` a square wave with period 2^(code+1) clk cycles, giving 384, 192, 96 and 48 times the sample rate.
- R4: `ratio_code` and `base_sel` are sampled only at the edge where the internal 32-state counter wraps. That counter starts from 0 after any reset, so a wrap falls at every 32nd edge after reset. A stopped output restarts only at such a wrap, and `mclk` is 0 right after each wrap.
- R5: If `gate`=1 or `run`=0 at a clock edge, `mclk` is 0 after that edge and stays 0 until a wrap with `gate`=0 and `run`=1.
- R6: A code above 4 with `base_sel`=0, or above 3 with `base_sel`=1, holds `mclk` at 0 from the wrap that samples it. The same wrap sets `cfg_err`, which stays at 1 until a reset, even after a legal code is loaded.
- R7: When `soft_rst`=1 at an edge, `mclk` and `cfg_err` are 0 after that edge and the counter restarts from 0.
- R8: `mclk_tick` is 1 for exactly those cycles in which `mclk` differs from its value one cycle earlier, including the fall caused by a soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock at twice the family clock rate |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| gate | input | 1 | 1 stops the output |
| run | input | 1 | 1 lets the output run |
| base_sel | input | 1 | Clock family: 0 for 512fs, 1 for 384fs |
| ratio_code | input | 3 | Log2 of the divisor |
| mclk | output | 1 | Divided master clock |
| mclk_tick | output | 1 | One-cycle pulse on each `mclk` transition |
| cfg_err | output | 1 | Sticky illegal-code flag |

## Verification
The properties assume that every control input changes only between clock edges. They also assume that reset is held for at least two edges, so that the edge-report check has a defined earlier output value to compare against. The stimulus drives all inputs on the falling clock edge and holds reset for several cycles. Codes and family changes are applied at arbitrary points in the counter period, so the checks show that nothing takes effect before a wrap. Gate pulses, run drops and soft resets are also placed mid-period, where they cut a high phase short.

// File: rtl/mclk_div_pkg.sv
// Package: shared helpers for the master clock ratio divider.
// Assumes ratio codes are unsigned and the family select is one bit.
package mclk_div_pkg;

    // Legality of a ratio code for the selected clock family.
    function automatic logic code_illegal(
        input logic        base384,
        input logic [31:0] code,
        input int unsigned max512,
        input int unsigned max384
    );
        if (base384) begin
            return code > max384;
        end
        return code > max512;
    endfunction

endpackage

// File: rtl/mclk_phase_cnt.sv
// Module: free-running binary phase counter.
// Each bit k is the reference halved k+1 times. It flags the wrap edge,
// where every phase starts a new period at once. Assumes synchronous resets.
module mclk_phase_cnt #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    // Next count value and wrap detection.
    always_comb begin
        cnt_nxt = (!rst_n || soft_rst) ? '0 : cnt_q + 1'b1;
        wrap    = rst_n && !soft_rst && (cnt_q == {CNT_W{1'b1}});
    end

    // Counter register, cleared by either reset.
    always_ff @(posedge clk) begin
        cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/mclk_code_ctrl.sv
// Module: ratio code and enable control.
// Samples the code and family at counter wraps, judges legality, holds the
// sticky error flag and applies the immediate stop. It exposes next-state
// values so the output stage can register them in the same edge.
module mclk_code_ctrl
    import mclk_div_pkg::*;
#(
    parameter int unsigned CODE_W       = 3,
    parameter int unsigned MAX_CODE_512 = 4,
    parameter int unsigned MAX_CODE_384 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wrap,
    input  logic              gate,
    input  logic              run,
    input  logic              base_sel,
    input  logic [CODE_W-1:0] ratio_code,
    output logic [CODE_W-1:0] code_nxt,
    output logic              drive_nxt,
    output logic              cfg_err
);
    logic [CODE_W-1:0] code_q;
    logic              bad_q;
    logic              en_q;
    logic              bad_nxt;
    logic              en_nxt;
    logic              err_nxt;
    logic              req_bad;

    // Legality of the currently requested code.
    always_comb begin
        req_bad = code_illegal(base_sel, 32'(ratio_code), MAX_CODE_512, MAX_CODE_384);
    end

    // Next state: load at wrap, stop at once, restart only at wrap.
    always_comb begin
        code_nxt = code_q;
        bad_nxt  = bad_q;
        en_nxt   = en_q;
        err_nxt  = cfg_err;
        if (!rst_n || soft_rst) begin
            code_nxt = '0;
            bad_nxt  = 1'b0;
            en_nxt   = 1'b0;
            err_nxt  = 1'b0;
        end else begin
            if (wrap) begin
                code_nxt = ratio_code;
                bad_nxt  = req_bad;
                err_nxt  = cfg_err | req_bad;
            end
            if (gate || !run) begin
                en_nxt = 1'b0;
            end else if (wrap) begin
                en_nxt = 1'b1;
            end
        end
        drive_nxt = en_nxt && !bad_nxt;
    end

    // Control registers.
    always_ff @(posedge clk) begin
        code_q  <= code_nxt;
        bad_q   <= bad_nxt;
        en_q    <= en_nxt;
        cfg_err <= err_nxt;
    end
endmodule

// File: rtl/mclk_out_stage.sv
// Module: output register and edge report.
// Picks the counter phase named by the code and registers it as mclk. It
// also registers a pulse for each transition. Codes wider than the counter
// select a constant 0, which only happens when the output is not driven.
module mclk_out_stage #(
    parameter int unsigned CNT_W  = 5,
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [CNT_W-1:0]  cnt_nxt,
    input  logic [CODE_W-1:0] code_nxt,
    input  logic              drive_nxt,
    output logic              mclk,
    output logic              mclk_tick
);
    localparam int unsigned SEL_N = 1 << CODE_W;

    logic [SEL_N-1:0] phase_ext;
    logic             mclk_nxt;

    // Widen the phase vector to every code value.
    for (genvar i = 0; i < SEL_N; i++) begin : g_phase
        if (i < CNT_W) begin : g_live
            assign phase_ext[i] = cnt_nxt[i];
        end else begin : g_zero
            assign phase_ext[i] = 1'b0;
        end
    end

    // Next output level.
    always_comb begin
        mclk_nxt = (rst_n && !soft_rst && drive_nxt) ? phase_ext[code_nxt] : 1'b0;
    end

    // Output and edge-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mclk      <= 1'b0;
            mclk_tick <= 1'b0;
        end else begin
            mclk      <= mclk_nxt;
            mclk_tick <= mclk_nxt ^ mclk;
        end
    end
endmodule

// File: rtl/mclk_ratio_div.sv
// Module: top of the master clock ratio divider.
// Assumes clk runs at twice the 512fs or 384fs family clock, and that all
// controls are synchronous to clk. Changes take effect at counter wraps.
module mclk_ratio_div #(
    parameter int unsigned CODE_W       = 3,
    parameter int unsigned MAX_CODE_512 = 4,
    parameter int unsigned MAX_CODE_384 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              gate,
    input  logic              run,
    input  logic              base_sel,
    input  logic [CODE_W-1:0] ratio_code,
    output logic              mclk,
    output logic              mclk_tick,
    output logic              cfg_err
);
    localparam int unsigned CNT_W = MAX_CODE_512 + 1;

    logic [CNT_W-1:0]  cnt_nxt;
    logic              wrap;
    logic [CODE_W-1:0] code_nxt;
    logic              drive_nxt;

    mclk_phase_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .cnt_nxt  (cnt_nxt),
        .wrap     (wrap)
    );

    mclk_code_ctrl #(
        .CODE_W       (CODE_W),
        .MAX_CODE_512 (MAX_CODE_512),
        .MAX_CODE_384 (MAX_CODE_384)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .wrap       (wrap),
        .gate       (gate),
        .run        (run),
        .base_sel   (base_sel),
        .ratio_code (ratio_code),
        .code_nxt   (code_nxt),
        .drive_nxt  (drive_nxt),
        .cfg_err    (cfg_err)
    );

    mclk_out_stage #(.CNT_W(CNT_W), .CODE_W(CODE_W)) i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .cnt_nxt   (cnt_nxt),
        .code_nxt  (code_nxt),
        .drive_nxt (drive_nxt),
        .mclk      (mclk),
        .mclk_tick (mclk_tick)
    );
endmodule

// File: rtl/mclk_ratio_div_chk.sv
// Module: property checker for the master clock ratio divider, bound to the top.
// Assumes reset is held for at least two edges.
module mclk_ratio_div_chk #(
    parameter int unsigned CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              gate,
    input logic              run,
    input logic              base_sel,
    input logic [CODE_W-1:0] ratio_code,
    input logic              mclk,
    input logic              mclk_tick,
    input logic              cfg_err
);
    logic past_valid;

    // Marks cycles whose previous output value is defined.
    always_ff @(posedge clk) begin
        past_valid <= rst_n;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!mclk && !mclk_tick && !cfg_err));

    p_stop_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate || !run) |=> !mclk);

    p_soft_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!mclk && !cfg_err));

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !soft_rst) |=> cfg_err);

    p_tick_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid |-> (mclk_tick == (mclk != $past(mclk))));
endmodule

bind mclk_ratio_div mclk_ratio_div_chk #(.CODE_W(CODE_W)) i_chk (.*);

// File: tb/test_mclk_ratio_div.sv
// Bench: behavioural reference model compared with the outputs on every clock.
module test_mclk_ratio_div;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       gate = 1'b0;
    logic       run = 1'b0;
    logic       base_sel = 1'b0;
    logic [2:0] ratio_code = 3'd0;
    logic       mclk;
    logic       mclk_tick;
    logic       cfg_err;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference model state.
    int m_cnt = 0, m_code = 0, m_base = 0;
    bit m_bad = 0, m_en = 0, m_err = 0, m_mclk = 0, m_tick = 0;

    mclk_ratio_div i_mclk_ratio_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .gate       (gate),
        .run        (run),
        .base_sel   (base_sel),
        .ratio_code (ratio_code),
        .mclk       (mclk),
        .mclk_tick  (mclk_tick),
        .cfg_err    (cfg_err)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model update at each edge from the requirements, then compare.
    always @(posedge clk) begin
        bit nm;
        bit wrap;
        if (!rst_n || soft_rst) begin
            m_cnt = 0; m_code = 0; m_base = 0;
            m_bad = 0; m_en = 0; m_err = 0;
            nm = 0;
        end else begin
            wrap  = (m_cnt == 31);
            m_cnt = (m_cnt + 1) % 32;
            if (wrap) begin
                m_code = ratio_code;
                m_base = base_sel;
                m_bad  = m_base ? (m_code > 3) : (m_code > 4);
                if (m_bad) m_err = 1;
            end
            if (gate || !run) m_en = 0;
            else if (wrap) m_en = 1;
            nm = (m_en && !m_bad) ? bit'((m_cnt >> m_code) & 1) : 1'b0;
        end
        m_tick = rst_n ? (nm != m_mclk) : 1'b0;
        m_mclk = nm;
        #1;
        if (!done) begin
            check(cur_req, "mclk", int'(mclk), int'(m_mclk));
            check("R8", "mclk_tick", int'(mclk_tick), int'(m_tick));
            check(cur_req, "cfg_err", int'(cfg_err), int'(m_err));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cur_req = "R1";
        idle(4);
        #2;
        check("R1", "reset mclk", int'(mclk), 0);
        check("R1", "reset cfg_err", int'(cfg_err), 0);
        @(negedge clk);
        rst_n = 1'b1;
        run = 1'b1;
        // R2: 512 family, codes changed at odd points in the period (R4).
        cur_req = "R2";
        for (int c = 0; c <= 4; c++) begin
            ratio_code = 3'(c);
            idle(77 + c * 13);
        end
        // R3: 384 family.
        cur_req = "R3";
        base_sel = 1'b1;
        for (int c = 3; c >= 0; c--) begin
            ratio_code = 3'(c);
            idle(70 + c * 9);
        end
        // R4: a brief code change that reverts before a wrap has no effect.
        cur_req = "R4";
        ratio_code = 3'd1;
        idle(40);
        ratio_code = 3'd3;
        idle(3);
        ratio_code = 3'd1;
        idle(60);
        // R5: gate pulse and run drop mid-period.
        cur_req = "R5";
        ratio_code = 3'd2;
        idle(45);
        gate = 1'b1;
        idle(7);
        gate = 1'b0;
        idle(50);
        run = 1'b0;
        idle(20);
        run = 1'b1;
        idle(50);
        // R6: illegal codes in both families, then a legal one.
        cur_req = "R6";
        ratio_code = 3'd4;
        idle(70);
        base_sel = 1'b0;
        ratio_code = 3'd6;
        idle(40);
        ratio_code = 3'd0;
        idle(70);
        #2;
        check("R6", "sticky cfg_err", int'(cfg_err), 1);
        @(negedge clk);
        // R7: soft reset mid-high phase.
        cur_req = "R7";
        ratio_code = 3'd4;
        idle(90);
        soft_rst = 1'b1;
        @(negedge clk);
        check("R7", "soft mclk", int'(mclk), 0);
        check("R7", "soft cfg_err", int'(cfg_err), 0);
        soft_rst = 1'b0;
        idle(100);
        // R1 again: hard reset mid-run.
        cur_req = "R1";
        rst_n = 1'b0;
        idle(3);
        check("R1", "rerun reset mclk", int'(mclk), 0);
        rst_n = 1'b1;
        idle(40);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule